// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address by walking a two-level page table held in memory. A request carries the virtual address and the table base. The walker reads the first-level descriptor that the top twelve address bits select. Depending on that descriptor's type bits, it either finishes the walk with a 1MB or 16MB block mapping or reads a second-level descriptor from a coarse table.

The second-level type bits choose between a 64KB page and a 4KB page. The two page formats place the execute-never and type-extension fields differently, and the walker extracts both correctly. Large-page and supersection entries are replicated in the table, so the walker always reads the single entry that the virtual address indexes.

The result is presented with a one-cycle done pulse. It holds the physical address, a size code, execute-never, the permission bits and the type-extension bits. A fault result instead carries the fault flag and the level that faulted. Permission bits and type bits are passed through and not interpreted.

Top module: `ptw_walker`

## Requirements
- R1: The first read goes to address {base[31:14], va[31:20], 2'b00}. While the read is not granted, the request and address stay stable.
- R2: A first-level descriptor with bits[1:0]=01 causes a second read at {desc[31:10], va[19:12], 2'b00}. Descriptor bits [9:2] do not affect that address.
- R3: A first-level descriptor with bits[1:0]=10 and bit18=0 gives a section result: pa={desc[31:20], va[19:0]}, size code 2, xn=desc[4], ap=desc[11:10], apx=desc[15], tex=desc[14:12]. Only one read is made.
- R4: A first-level descriptor with bits[1:0]=10 and bit18=1 gives a supersection result: pa={desc[31:24], va[23:0]}, size code 3, with the permission fields taken as in R3.
- R5: A first-level descriptor with bits[1:0]=00 or 11 ends the walk after one read with fault=1, fault level 1, and pa, size and every field output zero.
- R6: A second-level descriptor with bits[1:0]=00 ends the walk with fault=1, fault level 2, and all other result outputs zero.
- R7: A second-level descriptor with bits[1:0]=01 gives pa={desc[31:16], va[15:0]}, size code 1, xn=desc[15] and tex=desc[14:12].
- R8: A second-level descriptor with bits[1]=1 gives pa={desc[31:12], va[11:0]}, size code 0, xn=desc[0] and tex=desc[8:6]. In both page formats, ap=desc[5:4] and apx=desc[9].
- R9: req_ready_o is high only while the walker is idle, and a request raised during a walk is ignored. done_o lasts exactly one cycle. A successful result has fault=0 and fault level 0.
- R10: After reset, req_ready_o=1, done_o=0 and mem_req_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, accepts a request |
| req_va_i | input | 32 | Virtual address |
| req_tbase_i | input | 32 | First-level table base |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read word address (byte address) |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Result valid, one-cycle pulse |
| fault_o | output | 1 | Translation fault |
| fault_lvl_o | output | 2 | Faulting level (1 or 2), 0 when no fault |
| pa_o | output | 32 | Physical address |
| size_o | output | 2 | 0=4KB, 1=64KB, 2=1MB, 3=16MB |
| xn_o | output | 1 | Execute-never |
| ap_o | output | 2 | Access permission |
| apx_o | output | 1 | Extended permission bit |
| tex_o | output | 3 | Type-extension bits |

## Verification
A wrong controller state shows up at the memory port within a cycle. Examples are a missing or extra read, a second read after a block mapping or a fault, or a read address that lacks the index bits. The bench counts reads and checks each address. A wrong decode shows up in the single cycle of done_o as a wrong size code or wrong field. Field values that differ between formats, such as execute-never in bit 15 or bit 0, make each misplaced field visible. A stuck or leaking busy state shows up as req_ready_o staying low, or as a late request being served.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned L1_IDX  = 12;
  localparam int unsigned L2_IDX  = 8;
  localparam int unsigned TB_W    = DW - L1_IDX - 2;  // 18
  localparam int unsigned CB_W    = DW - L2_IDX - 2;  // 22

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_64K  = 2'd1;
  localparam logic [1:0] SZ_1M   = 2'd2;
  localparam logic [1:0] SZ_16M  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic          fault;
    logic [1:0]    lvl;
    logic [DW-1:0] pa;
    logic [1:0]    size;
    logic          xn;
    logic [1:0]    ap;
    logic          apx;
    logic [2:0]    tex;
  } walk_res_t;

  localparam walk_res_t RES_ZERO = '0;
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
  import ptw_pkg::*;
(
  input  logic [DW-1:0]   desc_i,
  input  logic [DW-1:0]   va_i,
  output logic            next_lvl_o,
  output logic [CB_W-1:0] cbase_o,
  output walk_res_t       res_o
);
  always_comb begin
    res_o      = RES_ZERO;
    next_lvl_o = 1'b0;
    cbase_o    = desc_i[DW-1:DW-CB_W];
    unique case (desc_i[1:0])
      2'b01: next_lvl_o = 1'b1;
      2'b10: begin
        res_o.xn  = desc_i[4];
        res_o.ap  = desc_i[11:10];
        res_o.apx = desc_i[15];
        res_o.tex = desc_i[14:12];
        if (desc_i[18]) begin
          res_o.size = SZ_16M;
          res_o.pa   = {desc_i[31:24], va_i[23:0]};
        end else begin
          res_o.size = SZ_1M;
          res_o.pa   = {desc_i[31:20], va_i[19:0]};
        end
      end
      default: begin
        res_o.fault = 1'b1;
        res_o.lvl   = 2'd1;
      end
    endcase
  end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
  import ptw_pkg::*;
(
  input  logic [DW-1:0] desc_i,
  input  logic [DW-1:0] va_i,
  output walk_res_t     res_o
);
  always_comb begin
    res_o = RES_ZERO;
    if (desc_i[1]) begin
      res_o.size = SZ_4K;
      res_o.pa   = {desc_i[31:12], va_i[11:0]};
      res_o.xn   = desc_i[0];
      res_o.tex  = desc_i[8:6];
      res_o.ap   = desc_i[5:4];
      res_o.apx  = desc_i[9];
    end else if (desc_i[0]) begin
      res_o.size = SZ_64K;
      res_o.pa   = {desc_i[31:16], va_i[15:0]};
      res_o.xn   = desc_i[15];
      res_o.tex  = desc_i[14:12];
      res_o.ap   = desc_i[5:4];
      res_o.apx  = desc_i[9];
    end else begin
      res_o.fault = 1'b1;
      res_o.lvl   = 2'd2;
    end
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [DW-1:0]   req_va_i,
  input  logic [DW-1:0]   req_tbase_i,
  output logic            mem_req_o,
  output logic [DW-1:0]   mem_addr_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  output logic [DW-1:0]   va_o,
  input  logic            l1_next_i,
  input  logic [CB_W-1:0] l1_cbase_i,
  input  walk_res_t       l1_res_i,
  input  walk_res_t       l2_res_i,
  output logic            done_o,
  output walk_res_t       res_o
);
  walk_st_e        st_q, st_d;
  logic [DW-1:0]   va_q;
  logic [TB_W-1:0] tb_q;
  logic [CB_W-1:0] cb_q;
  walk_res_t       res_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_valid_i) st_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_gnt_i) st_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rvalid_i) st_d = l1_next_i ? ST_L2_REQ : ST_DONE;
      ST_L2_REQ:  if (mem_gnt_i) st_d = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rvalid_i) st_d = ST_DONE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      va_q  <= '0;
      tb_q  <= '0;
      cb_q  <= '0;
      res_q <= RES_ZERO;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid_i) begin
        va_q <= req_va_i;
        tb_q <= req_tbase_i[DW-1:DW-TB_W];
      end
      if (st_q == ST_L1_WAIT && mem_rvalid_i) begin
        cb_q  <= l1_cbase_i;
        res_q <= l1_next_i ? RES_ZERO : l1_res_i;
      end
      if (st_q == ST_L2_WAIT && mem_rvalid_i) res_q <= l2_res_i;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
  assign mem_addr_o  = (st_q == ST_L2_REQ) ? {cb_q, va_q[19:12], 2'b00}
                                           : {tb_q, va_q[31:20], 2'b00};
  assign done_o      = (st_q == ST_DONE);
  assign res_o       = res_q;
  assign va_o        = va_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o)); // R1
  AST_FAULT_LVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (res_o.fault ? (res_o.lvl != 2'd0) : (res_o.lvl == 2'd0))); // R5
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && res_o.fault |-> res_o.pa == '0 && !res_o.xn); // R6
  AST_SMALL_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !res_o.fault && res_o.size == SZ_4K |-> res_o.pa[11:0] == va_q[11:0]); // R8
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_va_i,
  input  logic [31:0]   req_tbase_i,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          done_o,
  output logic          fault_o,
  output logic [1:0]    fault_lvl_o,
  output logic [31:0]   pa_o,
  output logic [1:0]    size_o,
  output logic          xn_o,
  output logic [1:0]    ap_o,
  output logic          apx_o,
  output logic [2:0]    tex_o
);
  logic [DW-1:0]   va;
  logic            l1_next;
  logic [CB_W-1:0] l1_cbase;
  walk_res_t       l1_res, l2_res, res;

  ptw_l1_dec u_l1 (
    .desc_i(mem_rdata_i), .va_i(va),
    .next_lvl_o(l1_next), .cbase_o(l1_cbase), .res_o(l1_res)
  );

  ptw_l2_dec u_l2 (
    .desc_i(mem_rdata_i), .va_i(va), .res_o(l2_res)
  );

  ptw_fsm u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_va_i, .req_tbase_i,
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i,
    .va_o(va), .l1_next_i(l1_next), .l1_cbase_i(l1_cbase),
    .l1_res_i(l1_res), .l2_res_i(l2_res),
    .done_o, .res_o(res)
  );

  assign fault_o     = res.fault;
  assign fault_lvl_o = res.lvl;
  assign pa_o        = res.pa;
  assign size_o      = res.size;
  assign xn_o        = res.xn;
  assign ap_o        = res.ap;
  assign apx_o       = res.apx;
  assign tex_o       = res.tex;
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_va = '0, req_tbase = '0;
  logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        done, fault, xn, apx;
  logic [1:0]  flvl, size, ap;
  logic [31:0] pa;
  logic [2:0]  tex;

  ptw_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_tbase_i(req_tbase),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .fault_o(fault), .fault_lvl_o(flvl), .pa_o(pa),
    .size_o(size), .xn_o(xn), .ap_o(ap), .apx_o(apx), .tex_o(tex)
  );

  int n_tests = 0, n_fail = 0;
  logic [31:0] d1 = '0, d2 = '0;
  logic [31:0] a1 = '0, a2 = '0;
  int n_reads = 0, lat = 0, cnt = 0;
  logic busy = 1'b0;
  logic [31:0] rd_hold = '0;

  // memory model: grant at negedge, data after lat extra cycles
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    mem_gnt    = 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd_hold;
        busy       = 1'b0;
      end else cnt = cnt - 1;
    end else if (mem_req) begin
      mem_gnt = 1'b1;
      busy    = 1'b1;
      cnt     = lat;
      if (n_reads == 0) begin a1 = mem_addr; rd_hold = d1; end
      else begin a2 = mem_addr; rd_hold = d2; end
      n_reads = n_reads + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] va, input logic [31:0] tb);
    n_reads = 0;
    @(negedge clk);
    chk("R9 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_va = va; req_tbase = tb;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input bit poke_busy);
    int k = 0;
    while (!done && k < 60) begin
      if (poke_busy && k < 3) begin
        chk("R9 ready low while busy", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b1; req_va = 32'hFFFF_FFFF; req_tbase = 32'hFFFF_FFFF;
      end else req_valid = 1'b0;
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    chk("R9 done seen", {31'd0, done}, 32'd1);
  endtask

  task automatic check_res(input string tag, input logic f, input logic [1:0] lv,
                           input logic [31:0] epa, input logic [1:0] esz, input logic ex,
                           input logic [1:0] eap, input logic eapx, input logic [2:0] etex,
                           input int nrd);
    chk({tag, " fault"}, {31'd0, fault}, {31'd0, f});
    chk({tag, " level"}, {30'd0, flvl}, {30'd0, lv});
    chk({tag, " pa"}, pa, epa);
    chk({tag, " size"}, {30'd0, size}, {30'd0, esz});
    chk({tag, " xn"}, {31'd0, xn}, {31'd0, ex});
    chk({tag, " ap"}, {30'd0, ap}, {30'd0, eap});
    chk({tag, " apx"}, {31'd0, apx}, {31'd0, eapx});
    chk({tag, " tex"}, {29'd0, tex}, {29'd0, etex});
    chk({tag, " reads"}, n_reads, nrd);
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    chk("R10 done", {31'd0, done}, 32'd0);
    chk("R10 mem_req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_section();
    lat = 0; d1 = 32'hABC0_DC12;
    start(32'h1234_5678, 32'h8000_4000);
    wait_done(0);
    chk("R1 l1 addr", a1, 32'h8000_448C);
    check_res("R3 section", 0, 0, 32'hABC4_5678, 2'd2, 1, 2'd3, 1, 3'd5, 1);
  endtask

  task automatic t_super();
    lat = 2; d1 = 32'h5F04_0002;
    start(32'h1234_5678, 32'h0000_0000);
    wait_done(0);
    chk("R1 l1 addr slow", a1, 32'h0000_048C);
    check_res("R4 supersection", 0, 0, 32'h5F34_5678, 2'd3, 0, 2'd0, 0, 3'd0, 1);
  endtask

  task automatic t_large();
    lat = 1; d1 = 32'h7654_3DE1; d2 = 32'h9ABC_B011;
    start(32'h0FED_CBA9, 32'h0000_C000);
    wait_done(0);
    chk("R1 l1 addr", a1, 32'h0000_C3F8);
    chk("R2 l2 addr", a2, 32'h7654_3F70);
    check_res("R7 large page", 0, 0, 32'h9ABC_CBA9, 2'd1, 1, 2'd1, 0, 3'd3, 2);
  endtask

  task automatic t_small_xn();
    lat = 0; d1 = 32'h7654_3DE1; d2 = 32'h1357_93A3;
    start(32'h0FED_CBA9, 32'h0000_C000);
    wait_done(0);
    chk("R2 l2 addr", a2, 32'h7654_3F70);
    check_res("R8 small page xn", 0, 0, 32'h1357_9BA9, 2'd0, 1, 2'd2, 1, 3'd6, 2);
  endtask

  task automatic t_small_busy();
    lat = 3; d1 = 32'h7654_3DE1; d2 = 32'h2468_A002;
    start(32'h0FED_CBA9, 32'h0000_C000);
    wait_done(1);
    check_res("R8 small page busy", 0, 0, 32'h2468_ABA9, 2'd0, 0, 2'd0, 0, 3'd0, 2);
    chk("R9 late request ignored: ready", {31'd0, req_ready}, 32'd1);
    chk("R9 late request ignored: reads", n_reads, 2);
  endtask

  task automatic t_l1_fault(input logic [31:0] d, input string tag);
    lat = 0; d1 = d;
    start(32'h4000_0000, 32'h0001_0000);
    wait_done(0);
    check_res(tag, 1, 2'd1, 32'd0, 2'd0, 0, 2'd0, 0, 3'd0, 1);
  endtask

  task automatic t_l2_fault();
    lat = 1; d1 = 32'h0000_0401; d2 = 32'hFFFF_FFFC;
    start(32'h0030_5000, 32'h0001_0000);
    wait_done(0);
    chk("R2 l2 addr", a2, 32'h0000_0414);
    check_res("R6 l2 fault", 1, 2'd2, 32'd0, 2'd0, 0, 2'd0, 0, 3'd0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_section();
    t_super();
    t_large();
    t_small_xn();
    t_small_busy();
    t_l1_fault(32'hFFFF_FFFC, "R5 l1 type00");
    t_l1_fault(32'h1234_5673, "R5 l1 type11");
    t_l2_fault();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule